// File: doc/BRIEF.md
# Tamper Detect and Memory Clear Controller

The block watches two tamper pins on behalf of a secure device. Each channel has an enable, a sense-level selector and two clear actions. The sense-level selector lets a switch that is normally open or normally closed, wired to either rail, be monitored. Pin levels are synchronised and debounced before any action is taken. A qualified event on an enabled channel does four things:
- It sets a sticky per-channel flag.
- It snapshots the incoming seconds count into a frozen time view.
- It can sweep a 128-byte scratch RAM to zero.
- It can raise an external clear strobe for a programmable number of 1 Hz ticks.

Software reaches the scratch RAM, the controls, the status and the time view through a byte-wide register port. The port writes on the clock edge and reads combinationally. The time view keeps showing the moment of the first tamper until the enable of the channel that caused the freeze is written to 0. The seconds counter itself is external and keeps running throughout.

Top module: `tamper_guard`

## Requirements
- R1: After reset the status byte (address 0x83) reads 0, `strobe_o` is low, and the time bytes at 0x84..0x87 (least significant byte at 0x84) show `time_i` live.
- R2: A pin level is acted on only after three consecutive synchronised samples agree. A pulse that lasts two clocks raises no flag.
- R3: Control byte bit 1 selects the sense level. With bit 1 = 0 a high pin is a tamper; with bit 1 = 1 a low pin is a tamper. The control byte is at 0x80 for channel 0 and 0x81 for channel 1.
- R4: While control bit 0 (enable) of a channel is 0, that channel's pin has no effect on the flags, the strobe, the time view or the scratch RAM.
- R5: Status bit 0 is the flag of channel 0 and status bit 1 is the flag of channel 1. A flag is set on its channel's event and stays set until 1 is written to its bit at 0x83.
- R6: The first event freezes the time view at the value of `time_i` at that event (status bit 3 = 1). A later event from either channel leaves the frozen value unchanged.
- R7: The view returns to live time only once control bit 0 of the channel that caused the freeze reads 0. Clearing the other channel's enable does not release it.
- R8: An event on a channel with control bit 2 set writes 0 to all 128 RAM bytes (addresses 0x00..0x7F), one per clock. While that sweep runs, RAM reads return 0 and RAM writes are dropped. Status bit 2 is 0 during the sweep and 1 once all bytes are written. Outside a sweep the RAM reads back what was written.
- R9: An event on a channel with control bit 3 set drives `strobe_o` high for 1, 4, 8 or 16 ticks of `tick_i`, selected by bits 1:0 of address 0x82 coded 00, 01, 10, 11. Without bit 3 set, the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register/RAM byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data |
| tamper_i | input | 2 | Tamper pins, asynchronous |
| tick_i | input | 1 | One-clock pulse per second |
| time_i | input | 32 | Free-running seconds count |
| strobe_o | output | 1 | External memory clear strobe |

## Verification
The bench builds the block with its default parameters: two channels, a 128-byte RAM, a three-sample debounce and a 5-bit pulse counter. With these values a full RAM sweep finishes within a couple of hundred clocks, so the bench can watch it both mid-sweep and after completion. Because `tick_i` is driven from the bench, all four strobe widths, including the 16-tick one, fit in a few hundred clocks. Each width is checked one tick before the strobe falls and again on the tick that ends it.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;

  // control byte fields
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_LOW  = 1;
  localparam int unsigned C_INT  = 2;
  localparam int unsigned C_EXT  = 3;
  localparam int unsigned C_BITS = 4;

  localparam logic [ADDR_W-1:0] A_CTRL0  = 8'h80;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 8'h82;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h83;
  localparam logic [ADDR_W-1:0] A_TIME0  = 8'h84;

  typedef struct packed {
    logic ext;
    logic int_clr;
    logic low;
    logic en;
  } ch_cfg_t;

  function automatic logic [4:0] pulse_len(input logic [1:0] sel);
    return (sel == 2'd0) ? 5'd1 : (5'd2 << sel);
  endfunction
endpackage

// File: rtl/tamper_chan.sv
module tamper_chan #(
  parameter int unsigned DB_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic low_i,
  output logic evt_o
);
  logic s1_q, s2_q, deb_q, qual_q;
  logic [DB_LEN-1:0] hist_q;
  logic qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= '0;
      deb_q  <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      hist_q <= {hist_q[DB_LEN-2:0], s2_q};
      if (&hist_q)       deb_q <= 1'b1;
      else if (~|hist_q) deb_q <= 1'b0;
      qual_q <= qual;
    end
  end

  assign qual  = en_i & (deb_q ^ low_i);
  assign evt_o = qual & ~qual_q;
endmodule

// File: rtl/tamper_scrub.sv
module tamper_scrub #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      ptr_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == AW'(DEPTH - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (busy_q)    mem[ptr_q]  <= '0;
    else if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = busy_q ? '0 : mem[addr_i];
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/tamper_strobe.sv
module tamper_strobe #(
  parameter int unsigned CNT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       strobe_o
);
  import tamper_pkg::*;
  logic [CNT_W-1:0] cnt_q;
  logic on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(pulse_len(sel_i));
      on_q  <= 1'b1;
    end else if (on_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign strobe_o = on_q;
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 128,
  parameter int unsigned TIME_W    = 32,
  parameter int unsigned DB_LEN    = 3,
  parameter int unsigned CNT_W     = 5,
  localparam int unsigned RAM_AW   = $clog2(RAM_DEPTH),
  localparam int unsigned T_BYTES  = TIME_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_CH-1:0]   tamper_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              strobe_o
);
  ch_cfg_t cfg_q [N_CH];
  logic [1:0] width_q;
  logic [N_CH-1:0] evt, flags_q;
  logic frozen_q, release_frz;
  logic [TIME_W-1:0] snap_q, view;
  logic trip_q, first_idx;
  logic start_int, start_ext;
  logic ram_sel, ram_we, clr_busy, clr_done;
  logic [DATA_W-1:0] ram_rdata;

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      tamper_chan #(.DB_LEN(DB_LEN)) u_chan (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (tamper_i[g]),
        .en_i  (cfg_q[g].en),
        .low_i (cfg_q[g].low),
        .evt_o (evt[g])
      );
    end
  endgenerate

  always_comb begin
    start_int = 1'b0;
    start_ext = 1'b0;
    first_idx = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      start_int = start_int | (evt[i] & cfg_q[i].int_clr);
      start_ext = start_ext | (evt[i] & cfg_q[i].ext);
      if (evt[i]) first_idx = 1'(i);
    end
  end

  // control, width and flag registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) cfg_q[i] <= '0;
      width_q <= '0;
      flags_q <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (reg_we_i && reg_addr_i == A_CTRL0 + ADDR_W'(i))
          cfg_q[i] <= ch_cfg_t'(reg_wdata_i[C_BITS-1:0]);
        if (evt[i])
          flags_q[i] <= 1'b1;
        else if (reg_we_i && reg_addr_i == A_STATUS && reg_wdata_i[i])
          flags_q[i] <= 1'b0;
      end
      if (reg_we_i && reg_addr_i == A_WIDTH) width_q <= reg_wdata_i[1:0];
    end
  end

  // time freeze
  assign release_frz = frozen_q && !cfg_q[trip_q].en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      snap_q   <= '0;
      trip_q   <= 1'b0;
    end else if (release_frz) begin
      frozen_q <= 1'b0;
    end else if (!frozen_q && |evt) begin
      frozen_q <= 1'b1;
      snap_q   <= time_i;
      trip_q   <= first_idx;
    end
  end

  assign view = frozen_q ? snap_q : time_i;

  assign ram_sel = (reg_addr_i[ADDR_W-1] == 1'b0);
  assign ram_we  = reg_we_i && ram_sel;

  tamper_scrub #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_scrub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_int),
    .we_i   (ram_we),
    .addr_i (reg_addr_i[RAM_AW-1:0]),
    .wdata_i(reg_wdata_i),
    .rdata_o(ram_rdata),
    .busy_o (clr_busy),
    .done_o (clr_done)
  );

  tamper_strobe #(.CNT_W(CNT_W)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ext),
    .sel_i   (width_q),
    .tick_i  (tick_i),
    .strobe_o(strobe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (ram_sel) begin
      reg_rdata_o = ram_rdata;
    end else begin
      for (int i = 0; i < N_CH; i++)
        if (reg_addr_i == A_CTRL0 + ADDR_W'(i))
          reg_rdata_o = DATA_W'(cfg_q[i]);
      if (reg_addr_i == A_WIDTH)  reg_rdata_o = DATA_W'(width_q);
      if (reg_addr_i == A_STATUS) reg_rdata_o = DATA_W'({frozen_q, clr_done, flags_q});
      for (int b = 0; b < T_BYTES; b++)
        if (reg_addr_i == A_TIME0 + ADDR_W'(b))
          reg_rdata_o = view[b*8 +: 8];
    end
  end
endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] evt,
  input logic [1:0] flags_q,
  input logic       reg_we_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       frozen_q,
  input logic [31:0] snap_q,
  input logic       clr_busy,
  input logic       clr_done,
  input logic       start_ext,
  input logic       strobe_o
);
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[0] |=> flags_q[0]); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[0] && !(reg_we_i && reg_addr_i == 8'h83 && reg_wdata_i[0]) |=> flags_q[0]); // R5
  AST_SNAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q && $past(frozen_q) |-> $stable(snap_q)); // R6
  AST_RAM_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_busy && !reg_addr_i[7] |-> reg_rdata_o == 8'h00); // R8
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_busy && clr_done)); // R8
  AST_STROBE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ext |=> strobe_o); // R9
  AST_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o && !start_ext |=> !strobe_o); // R9
endmodule

bind tamper_guard tamper_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt        (evt),
  .flags_q    (flags_q),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .frozen_q   (frozen_q),
  .snap_q     (snap_q),
  .clr_busy   (clr_busy),
  .clr_done   (clr_done),
  .start_ext  (start_ext),
  .strobe_o   (strobe_o)
);

// File: tb/tamper_guard_bench.sv
`timescale 1ns/1ps
module tamper_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic [1:0] pins = 2'b10;
  logic tick = 1'b0;
  logic [31:0] tnow = 32'd1000;
  logic strobe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always @(negedge clk) tnow <= tnow + 1;

  tamper_guard u_tamper_guard (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tamper_i(pins),
    .tick_i(tick), .time_i(tnow), .strobe_o(strobe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_time(output logic [31:0] t);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(8'h84 + 8'(i), b);
      t[i*8 +: 8] = b;
    end
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic cleanup();
    pins = 2'b10;
    wr(8'h80, 8'h00);
    wr(8'h81, 8'h00);
    idle(10);
    wr(8'h83, 8'h03);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h83, d); chk("R1 status", d, 8'h00);
    chk("R1 strobe", strobe, 1'b0);
    @(negedge clk); addr = 8'h84;
    #1 chk("R1 live time", rdata, tnow[7:0]);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    wr(8'h80, 8'h01);
    pins[0] = 1'b1; idle(2); pins[0] = 1'b0;
    idle(12);
    rd(8'h83, d); chk("R2 glitch ignored", d, 8'h00);
    cleanup();
  endtask

  task automatic t_detect();
    logic [7:0] d;
    logic [31:0] t1, t2;
    wr(8'h80, 8'h01);           // ch0 active high
    wr(8'h81, 8'h03);           // ch1 active low, pin idle high
    idle(10);
    rd(8'h83, d); chk("R3 idle levels no flag", d, 8'h00);
    pins[0] = 1'b1; idle(12);
    rd(8'h83, d); chk("R5 flag0 and freeze", d, 8'h09);
    chk("R9 no strobe without ext", strobe, 1'b0);
    rd_time(t1); idle(6); rd_time(t2);
    chk("R6 view frozen", t2, t1);
    chk("R6 frozen in window", (t1 < tnow && t1 > tnow - 40), 1'b1);
    pins[0] = 1'b0;
    pins[1] = 1'b0; idle(12);
    rd(8'h83, d); chk("R3 active-low flag1", d, 8'h0B);
    rd_time(t2); chk("R6 second event keeps snapshot", t2, t1);
    wr(8'h83, 8'h01); idle(2);
    rd(8'h83, d); chk("R5 w1c clears only flag0", d, 8'h0A);
    wr(8'h81, 8'h00); idle(3);
    rd_time(t2); chk("R7 other enable keeps freeze", t2, t1);
    wr(8'h80, 8'h00); idle(3);
    @(negedge clk); addr = 8'h84;
    #1 chk("R7 live after release", rdata, tnow[7:0]);
    rd(8'h83, d); chk("R7 freeze bit cleared", d, 8'h02);
    cleanup();
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(8'h10, 8'hA5);
    wr(8'h80, 8'h0C);           // clear actions set, enable off
    pins[0] = 1'b1; idle(15);
    rd(8'h83, d); chk("R4 no flag or freeze", d, 8'h00);
    chk("R4 no strobe", strobe, 1'b0);
    rd(8'h10, d); chk("R4 RAM kept", d, 8'hA5);
    cleanup();
  endtask

  task automatic t_ramclr();
    logic [7:0] d;
    wr(8'h00, 8'h11); wr(8'h3F, 8'h22); wr(8'h7F, 8'h33);
    rd(8'h7F, d); chk("R8 RAM readback", d, 8'h33);
    wr(8'h80, 8'h05);
    pins[0] = 1'b1; idle(20);
    rd(8'h7F, d); chk("R8 read zero during sweep", d, 8'h00);
    rd(8'h83, d); chk("R8 done low during sweep", d[2], 1'b0);
    idle(200);
    rd(8'h83, d); chk("R8 done after sweep", d[2], 1'b1);
    rd(8'h00, d); chk("R8 addr0 cleared", d, 8'h00);
    rd(8'h3F, d); chk("R8 addr63 cleared", d, 8'h00);
    rd(8'h7F, d); chk("R8 addr127 cleared", d, 8'h00);
    wr(8'h05, 8'h3C);
    rd(8'h05, d); chk("R8 RAM usable after", d, 8'h3C);
    cleanup();
  endtask

  task automatic t_strobe();
    for (int code = 0; code < 4; code++) begin
      int n;
      n = (code == 0) ? 1 : (2 << code);
      wr(8'h82, 8'(code));
      wr(8'h80, 8'h09);
      pins[0] = 1'b1; idle(12);
      chk($sformatf("R9 strobe up code %0d", code), strobe, 1'b1);
      for (int k = 0; k < n - 1; k++) tick_once();
      idle(1);
      chk($sformatf("R9 strobe held code %0d", code), strobe, 1'b1);
      tick_once(); idle(1);
      chk($sformatf("R9 strobe ends code %0d", code), strobe, 1'b0);
      cleanup();
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_glitch();
    t_detect();
    t_disabled();
    t_ramclr();
    t_strobe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule